// File: doc/BRIEF.md
# Panel Controller Power-Up Sequencer

This block brings a flat-panel controller from cold to a running state by stepping through a fixed list of register accesses. The controller sits behind an indexed register interface. A separate serial master, outside this block, carries each access to it. The sequencer starts when `start_i` rises. It then issues one request at a time over a valid/acknowledge handshake: a wake-up, a panel-off write, a batch of configuration writes and a revision read. When the revision matches, it loads a modulation table and applies a corrective rewrite of entry zero. It ends with a panel-on write. It raises `done_o` only after the final settle delay has passed.

The delays count whole milliseconds. A prescaler divides the clock, so a bench can set a low `CLK_HZ` and shorten the run. The configuration table, the modulation table seed, the register indices and the expected revision word are all parameters.

Top module: `panel_init_seq`

## Requirements
- R1: After reset, and until `start_i` is seen high, `done_o` and `req_valid_o` are both low.
- R2: The first request after start is a wake-up: `req_kind_o` = 0 (wake), `req_index_o` = 0, `req_wdata_o` = `WAKE_PULSES` (default 5). Kind codes: 0 wake, 1 write, 2 read.
- R3: The second request writes 0 to index 0x480 (panel off).
- R4: After the panel-off write is acknowledged, no request is issued for at least `DELAY_MS` × `CLK_HZ`/1000 cycles. The following request starts within three cycles after that.
- R5: Next come the configuration writes, in table order, to indices 0x400, 0x404, 0x40C, 0x410, 0x414, 0x418, 0x41C and 0x420, each carrying its parameterised 32-bit word.
- R6: A read of index 0x430 follows, with `req_wdata_o` = 0. Its data is taken from `rsp_rdata_i` in the acknowledge cycle.
- R7: If the read word equals `REV_ID` (default 0x92110201), then for each n from 0 to `FRM_DEPTH`-1 the block writes n to 0x418 and then the entry word to 0x41C. The entry word is {b, ~b, 3·b mod 256, b xor 0x5A} xor `FRM_SEED`, where b is the low byte of n.
- R8: After the last table entry, the block writes 0 to 0x418 and then writes 0 to 0x41C twice.
- R9: If the read word differs from `REV_ID`, no table or corrective writes are issued. The next request is the panel-on write.
- R10: The last request writes 0x01000000 to 0x480. `done_o` rises between `DELAY_MS` × `CLK_HZ`/1000 and three cycles more after its acknowledge, and no request is issued in between.
- R11: While `req_valid_o` is high and `req_ack_i` is low, the kind, index and data stay unchanged and the request stays valid. A request is accepted only in a cycle where both are high.
- R12: `done_o` stays high with no requests while `start_i` stays high, and falls in the cycle after `start_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts the sequence; held high until done is seen |
| done_o | output | 1 | Sequence finished |
| req_valid_o | output | 1 | Register request pending |
| req_kind_o | output | 2 | 0 wake, 1 write, 2 read |
| req_index_o | output | 12 | Register index |
| req_wdata_o | output | 32 | Write data, or pulse count for wake |
| req_ack_i | input | 1 | Master accepts the request |
| rsp_rdata_i | input | 32 | Read data, valid with the acknowledge of a read |

## Verification
The bench records every accepted request and compares the full list against one built independently, both for a revision match and for a mismatch. The list also covers the boundary cases.

- A design that skipped or duplicated the corrective rewrite would produce a list one entry off.
- A design that branched on the wrong revision compare would load the table on the mismatch run.
- An off-by-one table counter would stop at entry 62 or run to 64.

Acknowledge latency varies from request to request, so a design that advanced without an acknowledge would lose requests. Both millisecond waits are timed from acknowledge to next activity; a prescaler that reloads one short or long shows up as a gap outside its window.

// File: rtl/panel_init_pkg.sv
package panel_init_pkg;

   localparam int IDX_W  = 12;
   localparam int DATA_W = 32;

   typedef enum logic [1:0] {
      REQ_WAKE  = 2'd0,
      REQ_WRITE = 2'd1,
      REQ_READ  = 2'd2
   } req_kind_e;

   typedef enum logic [3:0] {
      ST_IDLE, ST_WAKE, ST_OFF, ST_DLY_OFF, ST_CFG, ST_REV,
      ST_TBL_ADR, ST_TBL_DAT, ST_FIX_ADR, ST_FIX_D1, ST_FIX_D2,
      ST_ON, ST_DLY_ON, ST_DONE
   } seq_state_e;

   // modulation table entry generator (contents are computed, not stored)
   function automatic logic [DATA_W-1:0] tbl_word(input logic [15:0] n,
                                                  input logic [DATA_W-1:0] seed);
      logic [7:0] b;
      logic [7:0] t;
      b = n[7:0];
      t = b * 8'd3;
      return {b, ~b, t, b ^ 8'h5A} ^ seed;
   endfunction

endpackage

// File: rtl/panel_ms_timer.sv
module panel_ms_timer #(
   parameter int CYC_PER_MS = 1000,
   parameter int DELAY_MS   = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_i,
   output logic busy_o,
   output logic expire_o
);
   localparam int PW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
   localparam int MW = $clog2(DELAY_MS + 1);

   logic [MW-1:0] ms_left;
   logic          busy;
   logic          tick;

   generate
      if (DELAY_MS < 1) begin : g_bad_delay
         $error("DELAY_MS must be at least 1");
      end
      if (CYC_PER_MS > 1) begin : g_pre
         logic [PW-1:0] pre;
         always_ff @(posedge clk) begin
            if (!rst_n)
               pre <= '0;
            else if (go_i || (busy && pre == '0))
               pre <= PW'(CYC_PER_MS - 1);
            else if (busy)
               pre <= pre - 1'b1;
         end
         assign tick = busy && (pre == '0);
      end else begin : g_nopre
         assign tick = busy;
      end
   endgenerate

   assign expire_o = tick && (ms_left == MW'(1));
   assign busy_o   = busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         ms_left <= '0;
      end else if (go_i) begin
         busy    <= 1'b1;
         ms_left <= MW'(DELAY_MS);
      end else if (expire_o) begin
         busy    <= 1'b0;
      end else if (tick) begin
         ms_left <= ms_left - 1'b1;
      end
   end
endmodule

// File: rtl/panel_cfg_rom.sv
module panel_cfg_rom #(
   parameter int                      COUNT     = 8,
   parameter int                      IW        = 12,
   parameter int                      DW        = 32,
   parameter logic [COUNT*IW-1:0]     INDEX_VEC = '0,
   parameter logic [COUNT*DW-1:0]     DATA_VEC  = '0,
   localparam int                     SW        = (COUNT > 1) ? $clog2(COUNT) : 1
) (
   input  logic [SW-1:0] sel_i,
   output logic [IW-1:0] index_o,
   output logic [DW-1:0] data_o
);
   logic [IW-1:0] idx_arr [COUNT];
   logic [DW-1:0] dat_arr [COUNT];

   generate
      for (genvar i = 0; i < COUNT; i++) begin : g_ent
         assign idx_arr[i] = INDEX_VEC[i*IW +: IW];
         assign dat_arr[i] = DATA_VEC[i*DW +: DW];
      end
   endgenerate

   always_comb begin
      index_o = '0;
      data_o  = '0;
      for (int k = 0; k < COUNT; k++) begin
         if (sel_i == SW'(k)) begin
            index_o = idx_arr[k];
            data_o  = dat_arr[k];
         end
      end
   end
endmodule

// File: rtl/panel_tbl_gen.sv
module panel_tbl_gen
   import panel_init_pkg::*;
#(
   parameter int                DEPTH = 64,
   parameter logic [DATA_W-1:0] SEED  = '0,
   localparam int               AW    = $clog2(DEPTH)
) (
   input  logic [AW-1:0]     addr_i,
   output logic [DATA_W-1:0] word_o
);
   generate
      if (DEPTH < 2 || DEPTH > 4096) begin : g_bad_depth
         $error("DEPTH out of range");
      end
   endgenerate

   assign word_o = tbl_word(16'(addr_i), SEED);
endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
   import panel_init_pkg::*;
#(
   parameter int                      CLK_HZ      = 100_000_000,
   parameter int                      DELAY_MS    = 128,
   parameter int                      WAKE_PULSES = 5,
   parameter int                      CFG_COUNT   = 8,
   parameter logic [CFG_COUNT*12-1:0] CFG_INDEX   = {12'h420, 12'h41C, 12'h418, 12'h414,
                                                     12'h410, 12'h40C, 12'h404, 12'h400},
   parameter logic [CFG_COUNT*32-1:0] CFG_DATA    = {32'h0000_0C03, 32'h6B1E_22D0, 32'h9F04_7A15,
                                                     32'h3C5A_E0F1, 32'h12D8_4B66, 32'h0000_0021,
                                                     32'h0002_8000, 32'h0320_0000},
   parameter logic [11:0]             PANEL_IDX   = 12'h480,
   parameter logic [11:0]             REV_IDX     = 12'h430,
   parameter logic [11:0]             TBL_ADR_IDX = 12'h418,
   parameter logic [11:0]             TBL_DAT_IDX = 12'h41C,
   parameter logic [31:0]             REV_ID      = 32'h9211_0201,
   parameter logic [31:0]             PANEL_ON    = 32'h0100_0000,
   parameter int                      FRM_DEPTH   = 64,
   parameter logic [31:0]             FRM_SEED    = 32'h0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   output logic        done_o,
   output logic        req_valid_o,
   output logic [1:0]  req_kind_o,
   output logic [11:0] req_index_o,
   output logic [31:0] req_wdata_o,
   input  logic        req_ack_i,
   input  logic [31:0] rsp_rdata_i
);
   localparam int CYC_PER_MS = CLK_HZ / 1000;
   localparam int CW         = (CFG_COUNT > 1) ? $clog2(CFG_COUNT) : 1;
   localparam int FW         = $clog2(FRM_DEPTH);

   generate
      if (CLK_HZ < 1000) begin : g_bad_clk
         $error("CLK_HZ must be at least 1000");
      end
      if (CFG_COUNT < 2) begin : g_bad_cfg
         $error("CFG_COUNT must be at least 2");
      end
      if (WAKE_PULSES < 1 || WAKE_PULSES > 255) begin : g_bad_wake
         $error("WAKE_PULSES out of range");
      end
   endgenerate

   seq_state_e    st;
   logic [CW-1:0] cfg_ptr;
   logic [FW-1:0] tbl_ptr;
   logic          acc;
   logic          tmr_go;
   logic          tmr_busy;
   logic          tmr_exp;
   logic [11:0]   cfg_idx;
   logic [31:0]   cfg_dat;
   logic [31:0]   tbl_dat;

   assign acc    = req_valid_o && req_ack_i;
   assign tmr_go = acc && (st == ST_OFF || st == ST_ON);

   panel_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .DELAY_MS(DELAY_MS)) u_tmr (
      .clk(clk), .rst_n(rst_n), .go_i(tmr_go), .busy_o(tmr_busy), .expire_o(tmr_exp)
   );

   panel_cfg_rom #(.COUNT(CFG_COUNT), .IW(12), .DW(32),
                   .INDEX_VEC(CFG_INDEX), .DATA_VEC(CFG_DATA)) u_cfg (
      .sel_i(cfg_ptr), .index_o(cfg_idx), .data_o(cfg_dat)
   );

   panel_tbl_gen #(.DEPTH(FRM_DEPTH), .SEED(FRM_SEED)) u_tbl (
      .addr_i(tbl_ptr), .word_o(tbl_dat)
   );

   // sequencing
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cfg_ptr <= '0;
         tbl_ptr <= '0;
      end else begin
         unique case (st)
            ST_IDLE:    begin
                           cfg_ptr <= '0;
                           tbl_ptr <= '0;
                           if (start_i) st <= ST_WAKE;
                        end
            ST_WAKE:    if (acc) st <= ST_OFF;
            ST_OFF:     if (acc) st <= ST_DLY_OFF;
            ST_DLY_OFF: if (tmr_exp) st <= ST_CFG;
            ST_CFG:     if (acc) begin
                           if (cfg_ptr == CW'(CFG_COUNT - 1)) st <= ST_REV;
                           else cfg_ptr <= cfg_ptr + 1'b1;
                        end
            ST_REV:     if (acc) begin
                           if (rsp_rdata_i == REV_ID) st <= ST_TBL_ADR;
                           else st <= ST_ON;
                        end
            ST_TBL_ADR: if (acc) st <= ST_TBL_DAT;
            ST_TBL_DAT: if (acc) begin
                           if (tbl_ptr == FW'(FRM_DEPTH - 1)) st <= ST_FIX_ADR;
                           else begin
                              tbl_ptr <= tbl_ptr + 1'b1;
                              st      <= ST_TBL_ADR;
                           end
                        end
            ST_FIX_ADR: if (acc) st <= ST_FIX_D1;
            ST_FIX_D1:  if (acc) st <= ST_FIX_D2;
            ST_FIX_D2:  if (acc) st <= ST_ON;
            ST_ON:      if (acc) st <= ST_DLY_ON;
            ST_DLY_ON:  if (tmr_exp) st <= ST_DONE;
            ST_DONE:    if (!start_i) st <= ST_IDLE;
            default:    st <= ST_IDLE;
         endcase
      end
   end

   // request decode
   always_comb begin
      req_valid_o = 1'b0;
      req_kind_o  = REQ_WRITE;
      req_index_o = '0;
      req_wdata_o = '0;
      unique case (st)
         ST_WAKE:    begin
                        req_valid_o = 1'b1;
                        req_kind_o  = REQ_WAKE;
                        req_wdata_o = 32'(WAKE_PULSES);
                     end
         ST_OFF:     begin
                        req_valid_o = 1'b1;
                        req_index_o = PANEL_IDX;
                     end
         ST_CFG:     begin
                        req_valid_o = 1'b1;
                        req_index_o = cfg_idx;
                        req_wdata_o = cfg_dat;
                     end
         ST_REV:     begin
                        req_valid_o = 1'b1;
                        req_kind_o  = REQ_READ;
                        req_index_o = REV_IDX;
                     end
         ST_TBL_ADR: begin
                        req_valid_o = 1'b1;
                        req_index_o = TBL_ADR_IDX;
                        req_wdata_o = 32'(tbl_ptr);
                     end
         ST_TBL_DAT: begin
                        req_valid_o = 1'b1;
                        req_index_o = TBL_DAT_IDX;
                        req_wdata_o = tbl_dat;
                     end
         ST_FIX_ADR: begin
                        req_valid_o = 1'b1;
                        req_index_o = TBL_ADR_IDX;
                     end
         ST_FIX_D1, ST_FIX_D2: begin
                        req_valid_o = 1'b1;
                        req_index_o = TBL_DAT_IDX;
                     end
         ST_ON:      begin
                        req_valid_o = 1'b1;
                        req_index_o = PANEL_IDX;
                        req_wdata_o = PANEL_ON;
                     end
         default:    ;
      endcase
   end

   assign done_o = (st == ST_DONE);
endmodule

module panel_init_seq_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        start_i,
   input logic        done_o,
   input logic        req_valid_o,
   input logic [1:0]  req_kind_o,
   input logic [11:0] req_index_o,
   input logic [31:0] req_wdata_o,
   input logic        req_ack_i,
   input logic        tmr_busy
);
   // R11: a pending request holds its fields until accepted
   a_r11_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && !req_ack_i) |=> (req_valid_o && $stable(req_kind_o) &&
                                       $stable(req_index_o) && $stable(req_wdata_o)));

   // R2: only the three defined kinds appear
   a_r2_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o |-> (req_kind_o != 2'd3));

   // R4 / R10: silence while a millisecond wait runs
   a_r4_quiet_delay: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_busy |-> !req_valid_o);

   // R12: no traffic once finished, and done held while start stays high
   a_r12_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !req_valid_o);

   a_r12_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && start_i) |=> done_o);

   a_r12_done_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> !done_o);
endmodule

bind panel_init_seq panel_init_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
   .req_valid_o(req_valid_o), .req_kind_o(req_kind_o), .req_index_o(req_index_o),
   .req_wdata_o(req_wdata_o), .req_ack_i(req_ack_i), .tmr_busy(tmr_busy)
);

// File: tb/panel_init_seq_test.sv
module panel_init_seq_test;
   localparam int CLK_HZ   = 8000;
   localparam int DELAY_MS = 128;
   localparam int DC       = DELAY_MS * (CLK_HZ / 1000);
   localparam int MAXT     = 200;
   localparam logic [31:0] REVW = 32'h9211_0201;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        done_o;
   logic        req_valid_o;
   logic [1:0]  req_kind_o;
   logic [11:0] req_index_o;
   logic [31:0] req_wdata_o;
   logic        req_ack_i;
   logic [31:0] rsp_rdata_i;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   logic [31:0] rev_word = 32'h0;

   logic [1:0]  lg_kind [MAXT];
   logic [11:0] lg_idx  [MAXT];
   logic [31:0] lg_dat  [MAXT];
   int          lg_ack  [MAXT];
   int          lg_seen [MAXT];
   int          lg_n = 0;

   logic [1:0]  ex_kind [MAXT];
   logic [11:0] ex_idx  [MAXT];
   logic [31:0] ex_dat  [MAXT];
   string       ex_tag  [MAXT];
   int          ex_n = 0;

   logic [11:0] cfg_i [8] = '{12'h400, 12'h404, 12'h40C, 12'h410,
                               12'h414, 12'h418, 12'h41C, 12'h420};
   logic [31:0] cfg_d [8] = '{32'h0320_0000, 32'h0002_8000, 32'h0000_0021, 32'h12D8_4B66,
                               32'h3C5A_E0F1, 32'h9F04_7A15, 32'h6B1E_22D0, 32'h0000_0C03};

   panel_init_seq #(.CLK_HZ(CLK_HZ), .DELAY_MS(DELAY_MS)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
      .req_valid_o(req_valid_o), .req_kind_o(req_kind_o), .req_index_o(req_index_o),
      .req_wdata_o(req_wdata_o), .req_ack_i(req_ack_i), .rsp_rdata_i(rsp_rdata_i)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic add(input logic [1:0] k, input logic [11:0] i, input logic [31:0] d, input string t);
      ex_kind[ex_n] = k; ex_idx[ex_n] = i; ex_dat[ex_n] = d; ex_tag[ex_n] = t;
      ex_n++;
   endtask

   task automatic build(input bit match);
      ex_n = 0;
      add(2'd0, 12'h000, 32'd5, "R2");
      add(2'd1, 12'h480, 32'h0, "R3");
      for (int i = 0; i < 8; i++) add(2'd1, cfg_i[i], cfg_d[i], "R5");
      add(2'd2, 12'h430, 32'h0, "R6");
      if (match) begin
         for (int n = 0; n < 64; n++) begin
            logic [7:0] b;
            logic [7:0] t;
            b = 8'(n);
            t = 8'((n * 3) % 256);
            add(2'd1, 12'h418, 32'(n), "R7");
            add(2'd1, 12'h41C, {b, ~b, t, b ^ 8'h5A}, "R7");
         end
         add(2'd1, 12'h418, 32'h0, "R8");
         add(2'd1, 12'h41C, 32'h0, "R8");
         add(2'd1, 12'h41C, 32'h0, "R8");
      end
      add(2'd1, 12'h480, 32'h0100_0000, match ? "R10" : "R9");
   endtask

   // register-master model with varying acknowledge latency
   initial begin
      int waitc;
      bit pend;
      req_ack_i = 1'b0;
      rsp_rdata_i = 32'h0;
      waitc = 0;
      pend = 1'b0;
      forever begin
         @(negedge clk);
         if (req_ack_i) begin
            req_ack_i = 1'b0;
            rsp_rdata_i = 32'h0;
         end else if (rst_n && req_valid_o && lg_n < MAXT) begin
            if (!pend) begin
               pend = 1'b1;
               lg_seen[lg_n] = cyc;
            end
            if (waitc >= lg_n % 3) begin
               lg_kind[lg_n] = req_kind_o;
               lg_idx[lg_n]  = req_index_o;
               lg_dat[lg_n]  = req_wdata_o;
               lg_ack[lg_n]  = cyc;
               lg_n++;
               req_ack_i = 1'b1;
               if (req_kind_o == 2'd2) rsp_rdata_i = rev_word;
               waitc = 0;
               pend = 1'b0;
            end else begin
               waitc++;
            end
         end
      end
   end

   task automatic run(input bit match);
      int t0;
      int dcyc;
      int last;
      rev_word = match ? REVW : (REVW ^ 32'h0000_0100);
      build(match);
      lg_n = 0;
      @(negedge clk);
      start_i = 1'b1;
      t0 = cyc;
      while (!done_o && cyc - t0 < 20000) @(negedge clk);
      dcyc = cyc;
      chk(done_o, "R10 done reached", 32'(done_o), 32'h1);
      chk(lg_n == ex_n, "R9 request count", 32'(lg_n), 32'(ex_n));
      for (int i = 0; i < ex_n && i < lg_n; i++) begin
         chk(lg_kind[i] == ex_kind[i] && lg_idx[i] == ex_idx[i] && lg_dat[i] == ex_dat[i],
             ex_tag[i], {lg_kind[i], 2'b0, lg_idx[i], lg_dat[i][15:0]},
             {ex_kind[i], 2'b0, ex_idx[i], ex_dat[i][15:0]});
         if (lg_dat[i] != ex_dat[i])
            chk(0, {ex_tag[i], " data word"}, lg_dat[i], ex_dat[i]);
      end
      if (lg_n >= 3) begin
         // R4: silence after panel-off acknowledge
         chk(lg_seen[2] - lg_ack[1] >= DC && lg_seen[2] - lg_ack[1] <= DC + 3,
             "R4 off delay", 32'(lg_seen[2] - lg_ack[1]), 32'(DC + 1));
         last = lg_n - 1;
         chk(dcyc - lg_ack[last] >= DC && dcyc - lg_ack[last] <= DC + 3,
             "R10 on delay", 32'(dcyc - lg_ack[last]), 32'(DC + 1));
      end
      // R12: done held while start high
      for (int k = 0; k < 10; k++) @(negedge clk);
      chk(done_o && !req_valid_o, "R12 done held", {30'h0, done_o, req_valid_o}, 32'h2);
      start_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(!done_o, "R12 done release", 32'(done_o), 32'h0);
      chk(!req_valid_o, "R12 idle after release", 32'(req_valid_o), 32'h0);
   endtask

   initial begin
      #(8 * 200000);
      bad++;
      total++;
      $display("FAIL R10 watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      for (int k = 0; k < 4; k++) @(negedge clk);
      chk(!done_o && !req_valid_o, "R1 reset state", {30'h0, done_o, req_valid_o}, 32'h0);
      rst_n = 1'b1;
      for (int k = 0; k < 6; k++) @(negedge clk);
      chk(!done_o && !req_valid_o, "R1 idle without start", {30'h0, done_o, req_valid_o}, 32'h0);
      run(1'b1);   // R7 R8: revision matches
      for (int k = 0; k < 5; k++) @(negedge clk);
      run(1'b0);   // R9: revision differs
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule